// File: doc/BRIEF.md
# Register Write-Protection Guard

This block sits in the write path between a simple register bus and a peripheral's configuration registers. While protection is armed, it drops every write that targets an offset inside a protected window. Each dropped write leaves a record: a sticky flag is raised and the offset of the blocked write is kept. Writes outside the window go through to the peripheral one cycle later with the same address and data.

Protection is armed and disarmed by writing a local control register. The upper 24 bits of that write must carry a fixed key value; a write with any other key is discarded. A read-only status word holds the sticky flag and the captured offset. Reading the status word returns its current contents and clears the flag. If a new violation arrives in the same cycle as that read, the flag stays set and the new offset is kept. Read data is registered and appears one cycle after the read request.

Top module: `wp_guard`

## Requirements
- R1: After reset, the status word reads 0, the control register reads 0 (protection disarmed) and no write is forwarded to the peripheral.
- R2: A write to the control offset whose data bits 31:8 equal KEY loads data bit 0 into the arm bit, and the arm bit can be read back in bit 0 of the control offset. Such a write is never forwarded.
- R3: A write to the control offset whose bits 31:8 differ from KEY leaves the arm bit unchanged.
- R4: While disarmed, writes inside the protected window are forwarded, and they do not change the status word.
- R5: While armed, a write inside the protected window is not forwarded. The next status read returns bit 0 = 1, and bits 23:8 hold that write's offset, zero-extended to 16 bits.
- R6: A write outside the protected window that is not to the control or status offset is forwarded on the next cycle with the same address and data, and it leaves the status word unchanged.
- R7: A status read returns the word as it stood before the read and clears bit 0. The captured offset stays in bits 23:8.
- R8: When a violation and a status read occur in the same cycle, the read returns the earlier word, bit 0 stays 1 and bits 23:8 take the new offset.
- R9: A later violation overwrites the captured offset.
- R10: The protected window is PROT_LO to PROT_HI inclusive. Offsets just outside either bound are not protected.
- R11: Status bits 31:24 and 7:1 always read 0. Reads of offsets other than the control and status offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 32 | Registered read data, valid one cycle after rd_en |
| per_wr_en | output | 1 | Forwarded write strobe to the peripheral |
| per_wr_addr | output | ADDR_W | Forwarded write offset |
| per_wr_data | output | 32 | Forwarded write data |

## Verification
The bench builds the block with ADDR_W = 16 and a protected window of 0x0010 to 0x003F. Because the window does not start at zero, the lower-bound compare is instantiated, so offsets on both sides of each bound can be driven. The control and status offsets (0x0080, 0x0084) lie above the window, which keeps the local registers apart from the protection decode. Each captured offset is a different value, so an overwrite or a stale capture shows up in the bits 23:8 of the next read.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int WORD_W   = 32;
  localparam int KEY_W    = 24;
  localparam int OFS_W    = 16;
  localparam int OFS_LSB  = 8;
  localparam int FLAG_BIT = 0;

  function automatic logic [WORD_W-1:0] pack_status(input logic flag,
                                                    input logic [OFS_W-1:0] ofs);
    logic [WORD_W-1:0] w;
    w = '0;
    w[FLAG_BIT] = flag;
    w[OFS_LSB +: OFS_W] = ofs;
    return w;
  endfunction
endpackage

// File: rtl/wp_mode_ctl.sv
module wp_mode_ctl #(
  parameter int ADDR_W = 16,
  parameter logic [wp_pkg::KEY_W-1:0] KEY = 24'hA5C3E1,
  parameter logic [ADDR_W-1:0] MODE_OFS = 'h80
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [wp_pkg::KEY_W-1:0] wr_key,
  input  logic                     wr_arm,
  output logic                     armed
);
  logic hit, key_ok;
  assign hit    = wr_en && (wr_addr == MODE_OFS);
  assign key_ok = (wr_key == KEY);

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else if (hit && key_ok) armed <= wr_arm;
  end

  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (hit && !key_ok) |=> $stable(armed)); // R3
  AST_GOOD_KEY_LOADS: assert property (@(posedge clk) disable iff (rst)
    (hit && key_ok) |=> (armed == $past(wr_arm))); // R2
endmodule

// File: rtl/wp_range_dec.sv
module wp_range_dec #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PROT_LO = '0,
  parameter logic [ADDR_W-1:0] PROT_HI = 'h7C
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win
);
  generate
    if (PROT_LO == '0) begin : g_top_only
      assign in_win = (addr <= PROT_HI);
    end else begin : g_both
      assign in_win = (addr >= PROT_LO) && (addr <= PROT_HI);
    end
  endgenerate
endmodule

// File: rtl/wp_capture.sv
module wp_capture #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              viol,
  input  logic [ADDR_W-1:0] viol_addr,
  input  logic              rd_clr,
  output logic              flag,
  output logic [ADDR_W-1:0] ofs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      ofs  <= '0;
    end else begin
      if (viol) begin
        flag <= 1'b1;
        ofs  <= viol_addr;
      end else if (rd_clr) begin
        flag <= 1'b0;
      end
    end
  end

  AST_VIOL_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    viol |=> (flag && ofs == $past(viol_addr))); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !viol) |=> (!flag && $stable(ofs))); // R7
  AST_RACE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && viol) |=> flag); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!rd_clr && !viol) |=> ($stable(flag) && $stable(ofs))); // R6
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int ADDR_W = 16,
  parameter logic [wp_pkg::KEY_W-1:0] KEY = 24'hA5C3E1,
  parameter logic [ADDR_W-1:0] PROT_LO = '0,
  parameter logic [ADDR_W-1:0] PROT_HI = 'h7C,
  parameter logic [ADDR_W-1:0] MODE_OFS = 'h80,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h84
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [wp_pkg::WORD_W-1:0] wr_data,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [wp_pkg::WORD_W-1:0] rd_data,
  output logic                      per_wr_en,
  output logic [ADDR_W-1:0]         per_wr_addr,
  output logic [wp_pkg::WORD_W-1:0] per_wr_data
);
  import wp_pkg::*;

  logic              armed, in_win, viol, fwd, local_wr, rd_clr, flag;
  logic [ADDR_W-1:0] ofs;
  logic [WORD_W-1:0] rd_next;

  wp_mode_ctl #(.ADDR_W(ADDR_W), .KEY(KEY), .MODE_OFS(MODE_OFS)) mode_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_key(wr_data[WORD_W-1 -: KEY_W]), .wr_arm(wr_data[0]), .armed(armed)
  );

  wp_range_dec #(.ADDR_W(ADDR_W), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) dec_i (
    .addr(wr_addr), .in_win(in_win)
  );

  assign local_wr = (wr_addr == MODE_OFS) || (wr_addr == STAT_OFS);
  assign viol     = wr_en && armed && in_win;
  assign fwd      = wr_en && !(armed && in_win) && !local_wr;
  assign rd_clr   = rd_en && (rd_addr == STAT_OFS);

  wp_capture #(.ADDR_W(ADDR_W)) cap_i (
    .clk(clk), .rst(rst), .viol(viol), .viol_addr(wr_addr),
    .rd_clr(rd_clr), .flag(flag), .ofs(ofs)
  );

  always_comb begin
    rd_next = '0;
    if (rd_en) begin
      if (rd_addr == STAT_OFS)      rd_next = pack_status(flag, OFS_W'(ofs));
      else if (rd_addr == MODE_OFS) rd_next[0] = armed;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      per_wr_en   <= 1'b0;
      per_wr_addr <= '0;
      per_wr_data <= '0;
    end else begin
      rd_data   <= rd_next;
      per_wr_en <= fwd;
      if (fwd) begin
        per_wr_addr <= wr_addr;
        per_wr_data <= wr_data;
      end
    end
  end

  AST_BLOCKED_NOT_FWD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && armed && in_win) |=> !per_wr_en); // R5
  AST_OPEN_WRITE_FWD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_win && !local_wr) |=>
      (per_wr_en && per_wr_addr == $past(wr_addr) && per_wr_data == $past(wr_data))); // R6
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data[31:24] == 8'h00 && rd_data[7:1] == 7'h00)); // R11
endmodule

// File: tb/wp_guard_tb.sv
module wp_guard_tb_top;
  localparam logic [15:0] LO = 16'h0010, HI = 16'h003F;
  localparam logic [15:0] MO = 16'h0080, ST = 16'h0084;
  localparam logic [31:0] ARM = 32'hA5C3E101, DISARM = 32'hA5C3E100, BADKEY = 32'hA5C3E001;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0;
  logic [15:0] wr_addr = '0, rd_addr = '0, per_wr_addr;
  logic [31:0] wr_data = '0, rd_data, per_wr_data;
  logic per_wr_en;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  wp_guard #(.ADDR_W(16), .PROT_LO(LO), .PROT_HI(HI), .MODE_OFS(MO), .STAT_OFS(ST)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .per_wr_en(per_wr_en), .per_wr_addr(per_wr_addr), .per_wr_data(per_wr_data)
  );

  typedef struct packed {
    logic        is_rd;
    logic [15:0] addr;
    logic [31:0] data;
    logic        exp_fwd;
    logic [31:0] exp_rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, ST,       32'h0,        1'b0, 32'h0,        4'd1},  // R1 status
    '{1'b1, MO,       32'h0,        1'b0, 32'h0,        4'd1},  // R1 control
    '{1'b0, 16'h0020, 32'h11111111, 1'b1, 32'h0,        4'd4},  // R4 disarmed pass
    '{1'b1, ST,       32'h0,        1'b0, 32'h0,        4'd4},  // R4 status untouched
    '{1'b0, MO,       BADKEY,       1'b0, 32'h0,        4'd3},  // R3 bad key
    '{1'b1, MO,       32'h0,        1'b0, 32'h0,        4'd3},  // R3 still disarmed
    '{1'b0, MO,       ARM,          1'b0, 32'h0,        4'd2},  // R2 arm
    '{1'b1, MO,       32'h0,        1'b0, 32'h1,        4'd2},  // R2 readback
    '{1'b0, 16'h0020, 32'h22222222, 1'b0, 32'h0,        4'd5},  // R5 blocked
    '{1'b0, 16'h0100, 32'h33333333, 1'b1, 32'h0,        4'd6},  // R6 open write
    '{1'b1, ST,       32'h0,        1'b0, 32'h00002001, 4'd5},  // R5 flag+offset, R11
    '{1'b1, ST,       32'h0,        1'b0, 32'h00002000, 4'd7},  // R7 cleared
    '{1'b0, LO,       32'h44444444, 1'b0, 32'h0,        4'd10}, // R10 low bound
    '{1'b1, ST,       32'h0,        1'b0, 32'h00001001, 4'd10}, // R10
    '{1'b0, HI,       32'h55555555, 1'b0, 32'h0,        4'd10}, // R10 high bound
    '{1'b0, 16'h0040, 32'h66666666, 1'b1, 32'h0,        4'd10}, // R10 above
    '{1'b0, 16'h000C, 32'h77777777, 1'b1, 32'h0,        4'd10}, // R10 below
    '{1'b1, ST,       32'h0,        1'b0, 32'h00003F01, 4'd9},  // R9 overwrite
    '{1'b0, MO,       DISARM,       1'b0, 32'h0,        4'd2},  // R2 disarm
    '{1'b0, 16'h0030, 32'h88888888, 1'b1, 32'h0,        4'd4},  // R4
    '{1'b1, ST,       32'h0,        1'b0, 32'h00003F00, 4'd4}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic w, input logic [15:0] wa, input logic [31:0] wd,
                       input logic r, input logic [15:0] ra);
    @(negedge clk);
    wr_en = w; wr_addr = wa; wr_data = wd; rd_en = r; rd_addr = ra;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string req);
    cycle(1'b0, '0, '0, 1'b1, a);
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 fwd", {31'b0, per_wr_en}, 32'h0);
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      if (VEC[i].is_rd) begin
        cycle(1'b0, '0, '0, 1'b1, VEC[i].addr);
        chk(tag, rd_data, VEC[i].exp_rd);
      end else begin
        cycle(1'b1, VEC[i].addr, VEC[i].data, 1'b0, '0);
        chk(tag, {31'b0, per_wr_en}, {31'b0, VEC[i].exp_fwd});
        if (VEC[i].exp_fwd) begin
          chk(tag, {16'b0, per_wr_addr}, {16'b0, VEC[i].addr});
          chk(tag, per_wr_data, VEC[i].data);
        end
      end
    end
    // R8: violation and status read in the same cycle
    cycle(1'b1, MO, ARM, 1'b0, '0);
    cycle(1'b1, 16'h0024, 32'h1, 1'b0, '0);
    cycle(1'b1, 16'h0028, 32'h2, 1'b1, ST);
    chk("R8 race read", rd_data, 32'h00002401);
    rd(ST, 32'h00002801, "R8 flag kept");
    rd(ST, 32'h00002800, "R7 cleared after race");
    // R11: unmapped read returns zero; write to status offset is not forwarded
    rd(16'h0100, 32'h0, "R11 unmapped read");
    cycle(1'b1, ST, 32'hFFFFFFFF, 1'b0, '0);
    chk("R11 status write", {31'b0, per_wr_en}, 32'h0);
    rd(ST, 32'h00002800, "R11 status unchanged");
    // R1: reset mid-run
    cycle(1'b1, 16'h0011, 32'h3, 1'b0, '0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(ST, 32'h0, "R1 status after reset");
    rd(MO, 32'h0, "R1 control after reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule